// File: doc/BRIEF.md
# Six-Address Software Store/Recall Detector

This block sits beside a battery-free nonvolatile SRAM and watches its ordinary read traffic for a secret knock. Software unlocks a transfer between the SRAM and its shadow nonvolatile array by reading six fixed addresses back to back. The first five addresses form a common preamble. The sixth picks the operation: one value asks for a store (SRAM copied into the nonvolatile cells), another asks for a recall (nonvolatile contents copied back into the SRAM), and a third value is kept for factory test and unlocks nothing.

Each address is taken on a falling edge of the active-low chip enable, after that edge has been synchronised to the block clock. The output-enable state plays no part. A write cycle, or any address that is out of order, throws the detector back to its start. If the offending address is itself the first preamble address, it counts as the first step of a new attempt. When a request is accepted, the block raises the matching request line and a disable line for the SRAM. It then ignores all of its inputs except the completion pulse from the nonvolatile engine. A store also needs the storage-capacitor-good input. A recall does not.

Top module: `nvs_seq_detect`

## Requirements
- R1: After reset, store_req, recall_req and sram_off are all 0 and the detector holds no partial progress. A sequence that was interrupted by reset must start again from its first address.
- R2: The preamble 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F on addr[13:0] must come as five consecutive reads. A sixth read of 0x0FC0, taken while cap_ok is 1, raises store_req and sram_off together on the clock edge that follows the synchronised chip-enable fall of that sixth read.
- R3: The preamble followed by a sixth read of 0x0C63 raises recall_req and sram_off together on the same edge as in R2, whatever the value of cap_ok.
- R4: A sixth read of 0x339C raises no output and returns the detector to its start. A following lone read of 0x0FC0 then requests nothing.
- R5: A read whose address is not the next expected one aborts the sequence. If that address is 0x0E38, it is counted as step one of a new sequence.
- R6: A write aborts the sequence. A write is we_n low at the chip-enable fall, or we_n falling while chip enable is held low. Writes made before a complete sequence do not prevent the store that follows.
- R7: A store sequence that ends while cap_ok is 0 is refused. No output rises and the detector returns to its start.
- R8: store_req and recall_req are never both 1. While either is 1, the request and sram_off stay 1 and chip-enable falls are ignored, until op_done is sampled 1. All three outputs are 0 on the following edge, and the detector restarts from step zero.
- R9: Only falling edges of ce_n capture an address. Changing addr while ce_n stays low advances nothing.
- R10: An op_done pulse while no operation is running has no effect on a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 14 | SRAM address bits 13..0 |
| ce_n | input | 1 | Active-low chip enable, synchronous to clk |
| we_n | input | 1 | Active-low write enable, synchronous to clk |
| op_done | input | 1 | Completion pulse from the nonvolatile engine |
| cap_ok | input | 1 | Storage capacitor above its safe level |
| store_req | output | 1 | Store operation requested and running |
| recall_req | output | 1 | Recall operation requested and running |
| sram_off | output | 1 | SRAM access disabled while an operation runs |

## Verification
The completion pulse of a running operation can land in the same clock cycle as a chip-enable fall that carries the first preamble address. Both events compete for the next state. The bench forces this collision by pulsing op_done and lowering ce_n with 0x0E38 on the same clock. It then reads the remaining five addresses of a store sequence. No store may result, because the strobe that coincided with completion must have been dropped rather than counted as step one. The same judgement is applied to strobes issued in the middle of a busy period.

// File: rtl/nvs_seq_pkg.sv
package nvs_seq_pkg;

    localparam int ADDR_W  = 14;
    localparam int PRE_LEN = 5;
    localparam int STEP_W  = $clog2(PRE_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    localparam addr_t STORE_CODE  = 14'h0FC0;
    localparam addr_t RECALL_CODE = 14'h0C63;
    localparam addr_t TEST_CODE   = 14'h339C;

    // Preamble addresses in the order they must be read.
    function automatic addr_t pre_code(input int idx);
        addr_t v;
        case (idx)
            0:       v = 14'h0E38;
            1:       v = 14'h31C7;
            2:       v = 14'h03E0;
            3:       v = 14'h3C1F;
            default: v = 14'h303F;
        endcase
        return v;
    endfunction

    typedef enum logic [1:0] {
        MODE_HUNT   = 2'd0,
        MODE_STORE  = 2'd1,
        MODE_RECALL = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        step_t step;
    } seq_state_t;

    typedef struct packed {
        logic ce;
        logic we;
    } strobe_state_t;

endpackage

// File: rtl/nvs_strobe.sv
module nvs_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic rd_evt,
    output logic wr_evt
);
    import nvs_seq_pkg::*;

    strobe_state_t st_d, st_q;
    logic ce_fall;
    logic we_fall_in_cycle;

    always_comb begin
        st_d    = st_q;
        st_d.ce = ce_n;
        st_d.we = we_n;

        ce_fall          = st_q.ce & ~ce_n;
        we_fall_in_cycle = ~ce_n & ~ce_fall & st_q.we & ~we_n;

        rd_evt = ce_fall & we_n;
        wr_evt = (ce_fall & ~we_n) | we_fall_in_cycle;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ce: 1'b1, we: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nvs_code_match.sv
module nvs_code_match (
    input  logic [nvs_seq_pkg::ADDR_W-1:0]  addr,
    output logic [nvs_seq_pkg::PRE_LEN-1:0] pre_hit,
    output logic                            hit_store,
    output logic                            hit_recall,
    output logic                            hit_test
);
    import nvs_seq_pkg::*;

    for (genvar i = 0; i < PRE_LEN; i++) begin : g_pre
        localparam addr_t CODE = pre_code(i);
        assign pre_hit[i] = (addr == CODE);
    end

    assign hit_store  = (addr == STORE_CODE);
    assign hit_recall = (addr == RECALL_CODE);
    assign hit_test   = (addr == TEST_CODE);

endmodule

// File: rtl/nvs_seq_fsm.sv
module nvs_seq_fsm (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_evt,
    input  logic                            wr_evt,
    input  logic [nvs_seq_pkg::PRE_LEN-1:0] pre_hit,
    input  logic                            hit_store,
    input  logic                            hit_recall,
    input  logic                            hit_test,
    input  logic                            op_done,
    input  logic                            cap_ok,
    output logic                            store_req,
    output logic                            recall_req,
    output logic                            sram_off
);
    import nvs_seq_pkg::*;

    localparam step_t LAST_STEP = step_t'(PRE_LEN);
    localparam step_t ONE_STEP  = step_t'(1);

    seq_state_t cur_d, cur_q;
    logic       expect_hit;
    step_t      restart_step;

    always_comb begin
        expect_hit = 1'b0;
        for (int i = 0; i < PRE_LEN; i++) begin
            if (cur_q.step == step_t'(i)) begin
                expect_hit = pre_hit[i];
            end
        end
        restart_step = pre_hit[0] ? ONE_STEP : '0;

        cur_d = cur_q;
        case (cur_q.mode)
            MODE_HUNT: begin
                if (wr_evt) begin
                    cur_d.step = '0;
                end else if (rd_evt) begin
                    if (cur_q.step != LAST_STEP) begin
                        cur_d.step = expect_hit ? cur_q.step + ONE_STEP : restart_step;
                    end else if (hit_store && cap_ok) begin
                        cur_d.mode = MODE_STORE;
                        cur_d.step = '0;
                    end else if (hit_recall) begin
                        cur_d.mode = MODE_RECALL;
                        cur_d.step = '0;
                    end else if (hit_test) begin
                        cur_d.step = '0;
                    end else begin
                        cur_d.step = restart_step;
                    end
                end
            end
            MODE_STORE, MODE_RECALL: begin
                if (op_done) begin
                    cur_d.mode = MODE_HUNT;
                    cur_d.step = '0;
                end
            end
            default: begin
                cur_d.mode = MODE_HUNT;
                cur_d.step = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{mode: MODE_HUNT, step: '0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign store_req  = (cur_q.mode == MODE_STORE);
    assign recall_req = (cur_q.mode == MODE_RECALL);
    assign sram_off   = (cur_q.mode != MODE_HUNT);

endmodule

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [nvs_seq_pkg::ADDR_W-1:0] addr,
    input  logic                           ce_n,
    input  logic                           we_n,
    input  logic                           op_done,
    input  logic                           cap_ok,
    output logic                           store_req,
    output logic                           recall_req,
    output logic                           sram_off
);
    import nvs_seq_pkg::*;

    logic               rd_evt;
    logic               wr_evt;
    logic [PRE_LEN-1:0] pre_hit;
    logic               hit_store;
    logic               hit_recall;
    logic               hit_test;

    nvs_strobe i_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .rd_evt (rd_evt),
        .wr_evt (wr_evt)
    );

    nvs_code_match i_match (
        .addr       (addr),
        .pre_hit    (pre_hit),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .hit_test   (hit_test)
    );

    nvs_seq_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_evt     (rd_evt),
        .wr_evt     (wr_evt),
        .pre_hit    (pre_hit),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .hit_test   (hit_test),
        .op_done    (op_done),
        .cap_ok     (cap_ok),
        .store_req  (store_req),
        .recall_req (recall_req),
        .sram_off   (sram_off)
    );

endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk (
    input logic                           clk,
    input logic                           rst_n,
    input logic [nvs_seq_pkg::ADDR_W-1:0] addr,
    input logic                           ce_n,
    input logic                           we_n,
    input logic                           op_done,
    input logic                           cap_ok,
    input logic                           store_req,
    input logic                           recall_req,
    input logic                           sram_off
);
    import nvs_seq_pkg::*;

    // R8
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_req, recall_req}));

    // R2
    store_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> ($past(addr) == STORE_CODE) && $past(we_n) && !$past(ce_n));

    // R7
    store_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_req) |-> $past(cap_ok));

    // R3
    recall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_req) |-> ($past(addr) == RECALL_CODE) && $past(we_n) && !$past(ce_n));

    // R8
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req && !op_done) |=> store_req);

    // R8
    recall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (recall_req && !op_done) |=> recall_req);

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_off && op_done) |=> !sram_off);

endmodule

bind nvs_seq_detect nvs_seq_chk i_chk (.*);

// File: tb/test_nvs_seq_detect.sv
module test_nvs_seq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        we_n = 1'b1;
    logic        op_done = 1'b0;
    logic        cap_ok = 1'b1;
    logic        store_req;
    logic        recall_req;
    logic        sram_off;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit reported = 1'b0;

    localparam logic [2:0] IDLE_OUT   = 3'b000;
    localparam logic [2:0] STORE_OUT  = 3'b101;
    localparam logic [2:0] RECALL_OUT = 3'b011;

    always #2 clk = ~clk;

    nvs_seq_detect i_nvs_seq_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .op_done    (op_done),
        .cap_ok     (cap_ok),
        .store_req  (store_req),
        .recall_req (recall_req),
        .sram_off   (sram_off)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !reported) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
            report();
        end
    end

    // outputs packed as {store_req, recall_req, sram_off}
    task automatic chk(input string req, input string what, input logic [2:0] exp);
        logic [2:0] act;
        act = {store_req, recall_req, sram_off};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ce_n  = 1'b1;
        we_n  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic [13:0] a);
        @(negedge clk);
        addr = a;
        we_n = 1'b1;
        ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [13:0] a);
        @(negedge clk);
        addr = a;
        we_n = 1'b0;
        ce_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_then_wr(input logic [13:0] a);
        @(negedge clk);
        addr = a;
        we_n = 1'b1;
        ce_n = 1'b0;
        @(negedge clk);
        we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1;
        we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic preamble();
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "outputs after reset", IDLE_OUT);
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        do_reset();
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R1", "progress cleared by reset", IDLE_OUT);
    endtask

    task automatic t_store();
        preamble();
        rd(14'h0FC0);
        chk("R2", "store accepted", STORE_OUT);
        rd(14'h0E38);
        chk("R8", "strobe during store ignored", STORE_OUT);
        finish_op();
        chk("R8", "store released by op_done", IDLE_OUT);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R8", "busy strobe not counted", IDLE_OUT);
    endtask

    task automatic t_recall();
        cap_ok = 1'b0;
        preamble();
        rd(14'h0C63);
        chk("R3", "recall with cap low", RECALL_OUT);
        finish_op();
        chk("R8", "recall released", IDLE_OUT);
        cap_ok = 1'b1;
    endtask

    task automatic t_cap();
        cap_ok = 1'b0;
        preamble();
        rd(14'h0FC0);
        chk("R7", "store refused with cap low", IDLE_OUT);
        cap_ok = 1'b1;
        rd(14'h0FC0);
        chk("R7", "refused store left detector idle", IDLE_OUT);
    endtask

    task automatic t_test_code();
        preamble();
        rd(14'h339C);
        chk("R4", "test code requests nothing", IDLE_OUT);
        rd(14'h0FC0);
        chk("R4", "detector idle after test code", IDLE_OUT);
    endtask

    task automatic t_abort();
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h1234);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R5", "wrong address aborts", IDLE_OUT);
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R5", "restart on first address mid-sequence", STORE_OUT);
        finish_op();
        preamble();
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0C63);
        chk("R5", "restart on first address at final step", RECALL_OUT);
        finish_op();
        chk("R5", "released", IDLE_OUT);
    endtask

    task automatic t_write();
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        wr(14'h3C1F);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R6", "write at strobe aborts", IDLE_OUT);
        rd(14'h0E38);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd_then_wr(14'h303F);
        rd(14'h0FC0);
        chk("R6", "write during held enable aborts", IDLE_OUT);
        wr(14'h0100);
        preamble();
        rd(14'h0FC0);
        chk("R6", "earlier writes do not block store", STORE_OUT);
        finish_op();
    endtask

    task automatic t_hold_ce();
        @(negedge clk);
        addr = 14'h0E38;
        we_n = 1'b1;
        ce_n = 1'b0;
        @(negedge clk);
        addr = 14'h31C7;
        @(negedge clk);
        addr = 14'h03E0;
        @(negedge clk);
        addr = 14'h3C1F;
        @(negedge clk);
        addr = 14'h303F;
        @(negedge clk);
        addr = 14'h0FC0;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        chk("R9", "held enable captures one address", IDLE_OUT);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R9", "held enable counted only as step one", STORE_OUT);
        finish_op();
    endtask

    task automatic t_same_cycle();
        preamble();
        rd(14'h0FC0);
        chk("R2", "store before collision", STORE_OUT);
        @(negedge clk);
        op_done = 1'b1;
        addr    = 14'h0E38;
        we_n    = 1'b1;
        ce_n    = 1'b0;
        @(negedge clk);
        op_done = 1'b0;
        ce_n    = 1'b1;
        chk("R8", "done and strobe collide, released", IDLE_OUT);
        @(negedge clk);
        rd(14'h31C7);
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R8", "colliding strobe dropped", IDLE_OUT);
    endtask

    task automatic t_idle_done();
        rd(14'h0E38);
        rd(14'h31C7);
        finish_op();
        rd(14'h03E0);
        rd(14'h3C1F);
        rd(14'h303F);
        rd(14'h0FC0);
        chk("R10", "idle op_done leaves progress", STORE_OUT);
        finish_op();
        chk("R10", "released", IDLE_OUT);
    endtask

    initial begin
        t_reset();
        t_store();
        t_recall();
        t_cap();
        t_test_code();
        t_abort();
        t_write();
        t_hold_ce();
        t_same_cycle();
        t_idle_done();
        report();
    end

endmodule